// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Unit

This unit stands between instruction fetch and the two execution pipes of a small in-order core: one integer pipe and one floating-point pipe. It keeps the next two instructions in program order in a two-slot queue and decodes both slots every cycle. For each slot it finds the instruction length, the scheduling class and the register fields. From these it decides whether the two can leave together.

When the two instructions form a legal pair and both pipes can accept work, a crossbar sends each instruction to its own pipe, swapping the slots when the older one is the floating-point op. Fetch is then asked for two new words. If the instructions cannot pair, only the older one leaves, and only when its pipe is ready. Whatever stays in the queue moves to the front. New words from fetch fill the empty slots in order, so the refill request always equals the number of empty slots after issue. Every issued instruction carries a tag that records its place in program order.

Top module: `dual_issue_pair`

## Requirements
- R1: Bit 0 of a word gives its length: 0 means 16 bits and 1 means 32 bits. A 16-bit word uses only bits [15:0], its register numbers are 3 bits wide and bits [31:16] are ignored. A 32-bit word extends each register number to 6 bits: rd takes bits [18:16] above [5:3], rn takes [21:19] above [8:6], and rm takes [24:22] above [11:9].
- R2: Bits [2:1] give the scheduling class: 0 alu, 1 load/store, 2 control, 3 fpu. Class fpu goes to the floating-point pipe and all other classes go to the integer pipe, whatever the slot order.
- R3: Two instructions may pair only when one is alu or load/store and the other is fpu. Control ops never pair.
- R4: Bit 12 set means the instruction writes rd. If bit 12 is clear, the instruction reads rd. Every instruction reads rn and rm. A pair is refused when either instruction writes a register that the other one reads or writes.
- R5: When a pair issues, both pipe outputs are valid in the same cycle, each carrying the right word, and the refill count is 2.
- R6: When no pair is possible, only the older instruction issues (refill count 1). If its pipe is not ready, nothing issues (refill count 0).
- R7: No instruction is issued to a pipe whose ready input is low. A pair needs both ready inputs high.
- R8: The tag of an issued instruction is the number of instructions issued since reset, modulo 2^TAG_W. Within a pair, the older instruction has the smaller tag.
- R9: Instructions that are not issued stay queued and move to the front. Empty slots fill from fetch_word0 first, then from fetch_word1.
- R10: After reset the queue is empty, nothing issues, the refill count is 2 and the tag count is 0. Reset is asserted asynchronously and released two clock edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_word0 | input | 32 | Next instruction from fetch, oldest |
| fetch_word1 | input | 32 | Instruction following fetch_word0 |
| int_ready | input | 1 | Integer pipe first stage is free |
| fp_ready | input | 1 | Floating-point pipe first stage is free |
| int_valid | output | 1 | Instruction issued to integer pipe |
| int_word | output | 32 | Integer pipe instruction word |
| int_tag | output | TAG_W | Program-order tag for integer pipe |
| fp_valid | output | 1 | Instruction issued to floating-point pipe |
| fp_word | output | 32 | Floating-point pipe instruction word |
| fp_tag | output | TAG_W | Program-order tag for floating-point pipe |
| refill_cnt | output | 2 | Number of new words taken from fetch this cycle |

## Verification
The bench sweeps every ordered pair of the four classes against every mix of lengths, every combination of the two ready inputs, and five register patterns. The patterns are: no overlap, older write against a younger source, younger write against an older source, a write against a destination that is read, and a near-miss. In the near-miss, the registers match only in their low three bits, so the result tells apart a correct length-dependent field decode from one that ignores the upper field bits or reads them in short words. Class pairs separate legal mixes from refused ones and show the slot swap. The ready combinations show the difference between a full pair, a lone older issue and a stall. One cycle later the bench checks which word is at the head of the queue and what tag it carries, which confirms that held entries were kept and that refills came in order.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int WORD_W   = 32;
  localparam int REG_LO_W = 3;
  localparam int REG_W    = 2 * REG_LO_W;

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_MEM = 2'd1,
    CLS_CTL = 2'd2,
    CLS_FPU = 2'd3
  } sched_cls_e;

  typedef struct packed {
    logic             wide;
    sched_cls_e       cls;
    logic             wr;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rn;
    logic [REG_W-1:0] rm;
  } slot_dec_t;
endpackage

// File: rtl/pair_decode.sv
module pair_decode
  import pair_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output slot_dec_t         dec
);
  logic [REG_LO_W-1:0] hi_rd, hi_rn, hi_rm;
  logic                unused_bits;

  // short words carry no upper register bits; their upper half is ignored
  always_comb begin
    hi_rd = word[0] ? word[18:16] : '0;
    hi_rn = word[0] ? word[21:19] : '0;
    hi_rm = word[0] ? word[24:22] : '0;
    dec.wide = word[0];
    dec.cls  = sched_cls_e'(word[2:1]);
    dec.wr   = word[12];
    dec.rd   = {hi_rd, word[5:3]};
    dec.rn   = {hi_rn, word[8:6]};
    dec.rm   = {hi_rm, word[11:9]};
  end

  assign unused_bits = ^{word[31:25], word[15:13]};
endmodule

// File: rtl/pair_hazard.sv
module pair_hazard
  import pair_pkg::*;
(
  input  slot_dec_t a,
  input  slot_dec_t b,
  output logic      clash
);
  function automatic logic hits(slot_dec_t w, slot_dec_t r);
    return w.wr && ((w.rd == r.rd) || (w.rd == r.rn) || (w.rd == r.rm));
  endfunction

  // rd of the other op is always touched: either written or read
  always_comb clash = hits(a, b) || hits(b, a);
endmodule

// File: rtl/pair_queue.sv
module pair_queue
  import pair_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WORD_W-1:0]      fetch_word0,
  input  logic [WORD_W-1:0]      fetch_word1,
  input  logic [1:0]             issue_n,
  output logic [1:0][WORD_W-1:0] q_word,
  output logic [1:0]             q_vld,
  output logic [TAG_W-1:0]       seq,
  output logic [1:0]             refill_n
);
  logic [1:0][WORD_W-1:0] rem_w, nxt_w;
  logic [1:0]             rem_v, nxt_v;
  logic                   load_en, seq_en;
  logic [TAG_W-1:0]       seq_nxt;

  always_comb begin
    rem_w = q_word;
    rem_v = q_vld;
    case (issue_n)
      2'd1: begin
        rem_w[0] = q_word[1];
        rem_v    = {1'b0, q_vld[1]};
      end
      2'd2:    rem_v = 2'b00;
      default: ;
    endcase
    nxt_w = rem_w;
    nxt_v = 2'b11;
    if (!rem_v[0]) begin
      nxt_w[0] = fetch_word0;
      nxt_w[1] = fetch_word1;
    end else if (!rem_v[1]) begin
      nxt_w[1] = fetch_word0;
    end
    refill_n = 2'd2 - ({1'b0, rem_v[0]} + {1'b0, rem_v[1]});
    load_en  = (refill_n != 2'd0) || (issue_n != 2'd0);
    seq_en   = (issue_n != 2'd0);
    seq_nxt  = seq + TAG_W'(issue_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= 2'b00;
      seq   <= '0;
    end else begin
      if (load_en) q_vld <= nxt_v;
      if (seq_en)  seq   <= seq_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) q_word <= nxt_w;
  end

  AST_SHIFT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_n == 2'd1) |=> (q_word[0] == $past(q_word[1]))); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_n == 2'd0 && q_vld == 2'b11) |=> $stable(q_word)); // R9
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_n == 2'd2) |=> (seq == $past(seq) + TAG_W'(2))); // R8
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import pair_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fetch_word0,
  input  logic [WORD_W-1:0] fetch_word1,
  input  logic              int_ready,
  input  logic              fp_ready,
  output logic              int_valid,
  output logic [WORD_W-1:0] int_word,
  output logic [TAG_W-1:0]  int_tag,
  output logic              fp_valid,
  output logic [WORD_W-1:0] fp_word,
  output logic [TAG_W-1:0]  fp_tag,
  output logic [1:0]        refill_cnt
);
  localparam int SLOTS = 2;

  logic [1:0]             rst_pipe;
  logic                   rst_s;
  logic [1:0][WORD_W-1:0] q_word;
  logic [1:0]             q_vld;
  logic [TAG_W-1:0]       seq;
  logic [1:0]             issue_n;
  slot_dec_t              dec [SLOTS];
  logic                   clash;
  logic                   old_fp, yng_fp, old_core, yng_core, mix_ok;
  logic                   pair_go, solo_go, old_ready;
  logic                   int_sel, fp_sel;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  pair_queue #(.TAG_W(TAG_W)) u_queue (
    .clk        (clk),
    .rst_n      (rst_s),
    .fetch_word0(fetch_word0),
    .fetch_word1(fetch_word1),
    .issue_n    (issue_n),
    .q_word     (q_word),
    .q_vld      (q_vld),
    .seq        (seq),
    .refill_n   (refill_cnt)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_dec
    pair_decode u_dec (.word(q_word[s]), .dec(dec[s]));
  end

  pair_hazard u_haz (.a(dec[0]), .b(dec[1]), .clash(clash));

  // pairing decision and crossbar
  always_comb begin
    old_fp    = (dec[0].cls == CLS_FPU);
    yng_fp    = (dec[1].cls == CLS_FPU);
    old_core  = (dec[0].cls == CLS_ALU) || (dec[0].cls == CLS_MEM);
    yng_core  = (dec[1].cls == CLS_ALU) || (dec[1].cls == CLS_MEM);
    mix_ok    = (old_core && yng_fp) || (old_fp && yng_core);
    pair_go   = (q_vld == 2'b11) && mix_ok && !clash && int_ready && fp_ready;
    old_ready = old_fp ? fp_ready : int_ready;
    solo_go   = !pair_go && q_vld[0] && old_ready;
    issue_n   = pair_go ? 2'd2 : (solo_go ? 2'd1 : 2'd0);
    int_sel   = pair_go && old_fp;
    fp_sel    = pair_go && !old_fp;
    int_valid = pair_go || (solo_go && !old_fp);
    fp_valid  = pair_go || (solo_go && old_fp);
    int_word  = q_word[int_sel];
    fp_word   = q_word[fp_sel];
    int_tag   = seq + TAG_W'(int_sel);
    fp_tag    = seq + TAG_W'(fp_sel);
  end

  AST_INT_READY: assert property (@(posedge clk) disable iff (!rst_s)
    int_valid |-> int_ready); // R7
  AST_FP_READY: assert property (@(posedge clk) disable iff (!rst_s)
    fp_valid |-> fp_ready); // R7
  AST_PAIR_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_s)
    (int_valid && fp_valid) |-> !clash); // R4
  AST_PAIR_TAGS: assert property (@(posedge clk) disable iff (!rst_s)
    (int_valid && fp_valid) |->
      (((int_tag - fp_tag) == TAG_W'(1)) || ((fp_tag - int_tag) == TAG_W'(1)))); // R8
  AST_REFILL_MATCH: assert property (@(posedge clk) disable iff (!rst_s)
    (q_vld == 2'b11) |-> (32'(refill_cnt) == $countones({int_valid, fp_valid}))); // R5
endmodule

// File: tb/test_dual_issue_pair.sv
`timescale 1ns/1ps
module test_dual_issue_pair;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [31:0]   fetch_word0, fetch_word1;
  logic          int_ready, fp_ready;
  logic          int_valid, fp_valid;
  logic [31:0]   int_word, fp_word;
  logic [TW-1:0] int_tag, fp_tag;
  logic [1:0]    refill_cnt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_issue_pair #(.TAG_W(TW)) i_dual_issue_pair (
    .clk(clk), .rst_n(rst_n),
    .fetch_word0(fetch_word0), .fetch_word1(fetch_word1),
    .int_ready(int_ready), .fp_ready(fp_ready),
    .int_valid(int_valid), .int_word(int_word), .int_tag(int_tag),
    .fp_valid(fp_valid), .fp_word(fp_word), .fp_tag(fp_tag),
    .refill_cnt(refill_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit wide, logic [1:0] cls, bit wr,
                                     logic [5:0] rd, logic [5:0] rn, logic [5:0] rm);
    logic [31:0] w;
    w = 32'h0;
    w[0] = wide; w[2:1] = cls; w[12] = wr; w[15:13] = 3'b101;
    w[5:3] = rd[2:0]; w[8:6] = rn[2:0]; w[11:9] = rm[2:0];
    if (wide) begin
      w[18:16] = rd[5:3]; w[21:19] = rn[5:3]; w[24:22] = rm[5:3];
      w[31:25] = 7'h2B;
    end else begin
      w[31:16] = 16'hA5A5;
    end
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    fetch_word0 = '0; fetch_word1 = '0; int_ready = 0; fp_ready = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(!int_valid && !fp_valid, "R10", "valid in reset", {int_valid, fp_valid}, 0);
    for (int ca = 0; ca < 4; ca++)
    for (int cb = 0; cb < 4; cb++)
    for (int la = 0; la < 2; la++)
    for (int lb = 0; lb < 2; lb++)
    for (int k = 0; k < 5; k++)
    for (int rdy = 0; rdy < 4; rdy++) begin
      logic [5:0] ard, arn, arm, brd, brn, brm;
      bit aw, bw, haz, compat, pair, ri, rf, afp, aok, hfp;
      logic [31:0] wa, wb, wx, wy, head;
      int issued;
      string req;
      ard = 1; arn = 2; arm = 3; aw = 1;
      brd = 4; brn = 5; brm = 6; bw = 1;
      case (k)
        1: brn = 1;
        2: arm = 4;
        3: begin brd = 1; bw = 0; end
        4: begin ard = la ? 6'd9 : 6'd1; brn = 1; end
        default: ;
      endcase
      haz = (k == 1) || (k == 2) || (k == 3) || (k == 4 && la == 0);
      compat = ((ca < 2) && cb == 3) || (ca == 3 && (cb < 2));
      ri = rdy[0]; rf = rdy[1];
      pair = compat && !haz && ri && rf;
      wa = mk(la[0], ca[1:0], aw, ard, arn, arm);
      wb = mk(lb[0], cb[1:0], bw, brd, brn, brm);
      wx = mk(0, 2'd0, 1, 6'd2, 6'd3, 6'd4);
      wy = mk(1, 2'd2, 0, 6'd7, 6'd6, 6'd5);
      if (k == 4) req = "R1";
      else if (!compat) req = "R3";
      else if (haz) req = "R4";
      else if (!(ri && rf)) req = "R7";
      else req = "R5";

      // reset, then load A,B
      @(negedge clk); rst_n = 0; int_ready = 0; fp_ready = 0;
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      @(negedge clk);
      fetch_word0 = wa; fetch_word1 = wb;
      #1;
      chk(!int_valid && !fp_valid && refill_cnt == 2, "R10", "empty queue",
          {int_valid, fp_valid, refill_cnt}, 64'h2);

      // decision cycle
      @(negedge clk);
      fetch_word0 = wx; fetch_word1 = wy; int_ready = ri; fp_ready = rf;
      #1;
      afp = (ca == 3);
      aok = afp ? rf : ri;
      if (pair) begin
        issued = 2;
        chk(int_valid && fp_valid, req, "pair valids", {int_valid, fp_valid}, 3);
        chk(int_word === (afp ? wb : wa), "R2", "int word", int_word, afp ? wb : wa);
        chk(fp_word === (afp ? wa : wb), "R2", "fp word", fp_word, afp ? wa : wb);
        chk(int_tag == (afp ? 1 : 0) && fp_tag == (afp ? 0 : 1), "R8", "pair tags",
            {int_tag, fp_tag}, afp ? 64'h10 : 64'h01);
        chk(refill_cnt == 2, "R5", "refill", refill_cnt, 2);
      end else if (aok) begin
        issued = 1;
        chk(int_valid == !afp && fp_valid == afp, req, "solo valids",
            {int_valid, fp_valid}, afp ? 1 : 2);
        chk((afp ? fp_word : int_word) === wa, "R2", "solo word",
            afp ? fp_word : int_word, wa);
        chk((afp ? fp_tag : int_tag) == 0, "R8", "solo tag", afp ? fp_tag : int_tag, 0);
        chk(refill_cnt == 1, "R6", "refill", refill_cnt, 1);
      end else begin
        issued = 0;
        chk(!int_valid && !fp_valid, "R7", "stall valids", {int_valid, fp_valid}, 0);
        chk(refill_cnt == 0, "R6", "refill", refill_cnt, 0);
      end

      // head of queue one cycle later
      @(negedge clk);
      fetch_word0 = 32'h0; fetch_word1 = 32'h0; int_ready = 1; fp_ready = 1;
      #1;
      head = (issued == 2) ? wx : (issued == 1 ? wb : wa);
      hfp = (issued == 2) ? 0 : (issued == 1 ? (cb == 3) : (ca == 3));
      if (hfp)
        chk(fp_valid && fp_word === head && fp_tag == TW'(issued), "R9", "head fp",
            {fp_tag, fp_word}, {TW'(issued), head});
      else
        chk(int_valid && int_word === head && int_tag == TW'(issued), "R9", "head int",
            {int_tag, int_word}, {TW'(issued), head});
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule